// File: doc/BRIEF.md
# Pad test-mode wrapper with NAND-tree continuity chain

This block sits between a chip's core and its pad ring and gives the package two board-level test modes. Neither mode needs a clock. Three functional input pads, the mode selects M2, M1 and M0, are read together with an active-low test-enable input. These four signals choose one of three modes: normal operation, a continuity test, or a mode in which every driver is off. A tester holds the select pads and the test-enable input steady for as long as it uses a test mode.

In the continuity test, each participating pad turns into an input. The pads feed a chain of two-input NAND stages in a fixed order around the die. Two dedicated observation pads keep driving: one shows an intermediate chain tap and the other shows the chain's end. Some pads have inverting receivers, and the select pads are among them. A tester drives those pads to 0 and every other chain pad to 1, so every stage sees a 1 from its pad. Forcing any single pad to the opposite level then produces a predictable change at the observation pads. An open or shorted pin shows up as a missing change. In normal operation, the core's output values and output enables go straight to the pads.

Top module: `ntt_pad_wrapper`

## Requirements
- R1: While test_en_n is 1, pad_out equals core_out and pad_oe equals core_oe on every pad.
- R2: While test_en_n is 0 and M2 (pad 7) or M0 (pad 5) reads 0, pad_oe is 0 on every pad except the tap pad (24) and the final pad (25), which are 1.
- R3: While test_en_n is 0 and M2, M1 (pad 6) and M0 all read 1, pad_oe is 0 on every pad, including pads 24 and 25.
- R4: While test_en_n is 0 with M2=1, M1=0 and M0=1, no test mode is active, and pad_out and pad_oe equal core_out and core_oe.
- R5: The chain is built as follows. Chain position k (0..23) reads pad (5 - k) mod 24. Its stage input is x_k = pad_in XOR inv, where inv is 1 for pads 1, 5, 6, 7, 10 and 15 and 0 for the others. Stage 0 is NOT x_0. Stage k is NAND(stage k-1, x_k). Pads 24 and 25 are not part of the chain.
- R6: In NAND-tree mode, pad_out[24] shows stage 11 and pad_out[25] shows stage 23. With every x_k at 1, both read 1.
- R7: In NAND-tree mode, suppose only chain position j has x_j = 0. Then pad_out[25] is 1 exactly when (23 - j) is even. pad_out[24] is 1 exactly when (11 - j) is even, for j up to 11, and stays 1 for j above 11.
- R8: The decode and the chain are purely combinational. The outputs settle after a change on any input without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| test_en_n | input | 1 | Active-low test enable; 1 keeps the block in normal operation |
| pad_in | input | 26 | Value received from each pad |
| core_out | input | 26 | Output value the core wants on each pad |
| core_oe | input | 26 | Output enable the core wants on each pad (1 = drive) |
| pad_out | output | 26 | Value sent to each pad driver |
| pad_oe | output | 26 | Enable sent to each pad driver (1 = drive) |

## Verification
The bench sweeps all sixteen combinations of test-enable and the three selects. It pays particular attention to the 101 select pattern. That pattern must leave the block in normal operation, and a decoder that treats "not all ones" as the continuity test would wrongly disable the drivers there. The bench drives the full stimulus and then walks one pad at a time across all 24 chain positions. These pads include the select pads themselves and the first stage, which has no predecessor. A wrong chain order, a missing inversion or a mis-built first stage would put the wrong parity on the tap pad or the final pad. The bench also toggles the two observation pads' own inputs. A design that folded them into the chain would change the result when they toggle.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC = 2'd0,
    MODE_NAND = 2'd1,
    MODE_HIZ  = 2'd2
  } test_mode_e;

  parameter int DEF_LEN = 24;
  parameter int IDX_W   = 8;

  // Default walk: start at a given pad and step downward around the ring.
  function automatic logic [DEF_LEN*IDX_W-1:0] default_order(int first);
    logic [DEF_LEN*IDX_W-1:0] ord;
    ord = '0;
    for (int k = 0; k < DEF_LEN; k++) begin
      ord[k*IDX_W +: IDX_W] = IDX_W'((DEF_LEN + first - k) % DEF_LEN);
    end
    return ord;
  endfunction

endpackage

// File: rtl/ntt_mode_decode.sv
module ntt_mode_decode (
  input  logic                  test_en_n,
  input  logic                  sel2,
  input  logic                  sel1,
  input  logic                  sel0,
  output ntt_pkg::test_mode_e   mode
);
  import ntt_pkg::*;

  always_comb begin
    if (test_en_n) begin
      mode = MODE_FUNC;
    end else if (!sel2 || !sel0) begin
      mode = MODE_NAND;
    end else if (sel1) begin
      mode = MODE_HIZ;
    end else begin
      mode = MODE_FUNC;
    end
  end

endmodule

// File: rtl/ntt_nand_chain.sv
module ntt_nand_chain #(
  parameter int NUM_PADS  = 26,
  parameter int CHAIN_LEN = ntt_pkg::DEF_LEN,
  parameter int TAP_POS   = 11,
  parameter logic [CHAIN_LEN*ntt_pkg::IDX_W-1:0] CHAIN_ORDER = ntt_pkg::default_order(5),
  parameter logic [NUM_PADS-1:0] INV_MASK = 26'h00084E2
) (
  input  logic [NUM_PADS-1:0] pad_in,
  output logic                tap_out,
  output logic                final_out
);
  localparam int IW = ntt_pkg::IDX_W;

  logic [CHAIN_LEN-1:0] stage_in;
  logic [CHAIN_LEN-1:0] stage_q;
  logic                 unused_pads;

  assign unused_pads = ^pad_in;

  for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_stage
    localparam int PAD = int'(CHAIN_ORDER[k*IW +: IW]);
    assign stage_in[k] = pad_in[PAD] ^ INV_MASK[PAD];
    if (k == 0) begin : g_first
      assign stage_q[k] = ~stage_in[k];
    end else begin : g_link
      assign stage_q[k] = ~(stage_q[k-1] & stage_in[k]);
    end
  end

  assign tap_out   = stage_q[TAP_POS];
  assign final_out = stage_q[CHAIN_LEN-1];

endmodule

// File: rtl/ntt_oe_override.sv
module ntt_oe_override #(
  parameter int NUM_PADS  = 26,
  parameter int TAP_PAD   = 24,
  parameter int FINAL_PAD = 25
) (
  input  ntt_pkg::test_mode_e  mode,
  input  logic [NUM_PADS-1:0]  core_out,
  input  logic [NUM_PADS-1:0]  core_oe,
  input  logic                 tap_val,
  input  logic                 final_val,
  output logic [NUM_PADS-1:0]  pad_out,
  output logic [NUM_PADS-1:0]  pad_oe
);
  import ntt_pkg::*;

  always_comb begin
    pad_out = core_out;
    pad_oe  = core_oe;
    case (mode)
      MODE_NAND: begin
        pad_oe             = '0;
        pad_oe[TAP_PAD]    = 1'b1;
        pad_oe[FINAL_PAD]  = 1'b1;
        pad_out[TAP_PAD]   = tap_val;
        pad_out[FINAL_PAD] = final_val;
      end
      MODE_HIZ: begin
        pad_oe = '0;
      end
      default: begin
        pad_oe = core_oe;
      end
    endcase
  end

endmodule

// File: rtl/ntt_pad_wrapper.sv
module ntt_pad_wrapper #(
  parameter int NUM_PADS  = 26,
  parameter int CHAIN_LEN = ntt_pkg::DEF_LEN,
  parameter int TAP_POS   = 11,
  parameter int TAP_PAD   = 24,
  parameter int FINAL_PAD = 25,
  parameter int SEL2_PAD  = 7,
  parameter int SEL1_PAD  = 6,
  parameter int SEL0_PAD  = 5,
  parameter logic [CHAIN_LEN*ntt_pkg::IDX_W-1:0] CHAIN_ORDER = ntt_pkg::default_order(5),
  parameter logic [NUM_PADS-1:0] INV_MASK = 26'h00084E2
) (
  input  logic                test_en_n,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  ntt_pkg::test_mode_e mode;
  logic tap_val;
  logic final_val;

  ntt_mode_decode u_decode (
    .test_en_n (test_en_n),
    .sel2      (pad_in[SEL2_PAD]),
    .sel1      (pad_in[SEL1_PAD]),
    .sel0      (pad_in[SEL0_PAD]),
    .mode      (mode)
  );

  ntt_nand_chain #(
    .NUM_PADS    (NUM_PADS),
    .CHAIN_LEN   (CHAIN_LEN),
    .TAP_POS     (TAP_POS),
    .CHAIN_ORDER (CHAIN_ORDER),
    .INV_MASK    (INV_MASK)
  ) u_chain (
    .pad_in    (pad_in),
    .tap_out   (tap_val),
    .final_out (final_val)
  );

  ntt_oe_override #(
    .NUM_PADS  (NUM_PADS),
    .TAP_PAD   (TAP_PAD),
    .FINAL_PAD (FINAL_PAD)
  ) u_override (
    .mode      (mode),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .tap_val   (tap_val),
    .final_val (final_val),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

endmodule

// File: rtl/ntt_pad_wrapper_chk.sv
module ntt_pad_wrapper_chk #(
  parameter int NUM_PADS  = 26,
  parameter int CHAIN_LEN = ntt_pkg::DEF_LEN,
  parameter int TAP_PAD   = 24,
  parameter int FINAL_PAD = 25,
  parameter int SEL2_PAD  = 7,
  parameter int SEL1_PAD  = 6,
  parameter int SEL0_PAD  = 5,
  parameter logic [CHAIN_LEN*ntt_pkg::IDX_W-1:0] CHAIN_ORDER = ntt_pkg::default_order(5),
  parameter logic [NUM_PADS-1:0] INV_MASK = 26'h00084E2
) (
  input logic                test_en_n,
  input logic [NUM_PADS-1:0] pad_in,
  input logic [NUM_PADS-1:0] core_out,
  input logic [NUM_PADS-1:0] core_oe,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] pad_oe
);
  localparam int IW = ntt_pkg::IDX_W;
  localparam logic [NUM_PADS-1:0] OBS_MASK =
    (NUM_PADS'(1) << TAP_PAD) | (NUM_PADS'(1) << FINAL_PAD);

  logic s2, s1, s0, nand_sel, hiz_sel, none_sel, stim_ok;

  assign s2 = pad_in[SEL2_PAD];
  assign s1 = pad_in[SEL1_PAD];
  assign s0 = pad_in[SEL0_PAD];
  assign nand_sel = !test_en_n && (!s2 || !s0);
  assign hiz_sel  = !test_en_n && s2 && s1 && s0;
  assign none_sel = !test_en_n && s2 && !s1 && s0;

  always_comb begin
    stim_ok = 1'b1;
    for (int k = 0; k < CHAIN_LEN; k++) begin
      if ((pad_in[int'(CHAIN_ORDER[k*IW +: IW])] ^
           INV_MASK[int'(CHAIN_ORDER[k*IW +: IW])]) == 1'b0) begin
        stim_ok = 1'b0;
      end
    end
  end

  always_comb begin
    if (test_en_n) begin
      assert_func_pass_R1: assert (pad_oe == core_oe && pad_out == core_out);
    end
    if (nand_sel) begin
      assert_nand_oe_R2: assert (pad_oe == OBS_MASK);
    end
    if (hiz_sel) begin
      assert_hiz_all_R3: assert (pad_oe == '0);
    end
    if (none_sel) begin
      assert_no_mode_R4: assert (pad_oe == core_oe && pad_out == core_out);
    end
    if (nand_sel && stim_ok) begin
      // R6: full stimulus leaves an even-length chain end at 1
      assert_full_stim_R6: assert (pad_out[FINAL_PAD] == 1'(((CHAIN_LEN - 1) % 2)));
    end
  end

endmodule

bind ntt_pad_wrapper ntt_pad_wrapper_chk #(
  .NUM_PADS    (NUM_PADS),
  .CHAIN_LEN   (CHAIN_LEN),
  .TAP_PAD     (TAP_PAD),
  .FINAL_PAD   (FINAL_PAD),
  .SEL2_PAD    (SEL2_PAD),
  .SEL1_PAD    (SEL1_PAD),
  .SEL0_PAD    (SEL0_PAD),
  .CHAIN_ORDER (CHAIN_ORDER),
  .INV_MASK    (INV_MASK)
) u_chk (
  .test_en_n (test_en_n),
  .pad_in    (pad_in),
  .core_out  (core_out),
  .core_oe   (core_oe),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/ntt_pad_wrapper_bench.sv
module ntt_pad_wrapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 26;
  localparam int LEN = 24;
  localparam logic [NP-1:0] OBS = (NP'(1) << 24) | (NP'(1) << 25);
  localparam logic [NP-1:0] INV = (NP'(1) << 1) | (NP'(1) << 5) | (NP'(1) << 6) |
                                  (NP'(1) << 7) | (NP'(1) << 10) | (NP'(1) << 15);
  localparam logic [NP-1:0] STIM = {2'b00, ~INV[23:0]};

  logic clk = 1'b0;
  logic test_en_n;
  logic [NP-1:0] pad_in, core_out, core_oe, pad_out, pad_oe;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ntt_pad_wrapper u_ntt_pad_wrapper (
    .test_en_n (test_en_n),
    .pad_in    (pad_in),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  task automatic check(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    #(CLK_PERIOD/3);
  endtask

  function automatic int pad_of(int k);
    return (5 - k + LEN) % LEN;
  endfunction

  task automatic t_idle();
    test_en_n = 1'b1; pad_in = '0; core_out = 26'h2C3A5F1; core_oe = 26'h13C96A5;
    settle();
    check("R1 idle out", pad_out, 26'h2C3A5F1);
    check("R1 idle oe", pad_oe, 26'h13C96A5);
    pad_in = STIM; core_out = 26'h0F0F0F0; settle();
    check("R8 no clock follow", pad_out, 26'h0F0F0F0);
  endtask

  task automatic t_decode();
    for (int te = 0; te < 2; te++) begin
      for (int m = 0; m < 8; m++) begin
        logic [NP-1:0] exp_oe;
        test_en_n = te[0];
        pad_in = STIM;
        pad_in[7] = m[2]; pad_in[6] = m[1]; pad_in[5] = m[0];
        settle();
        if (te == 1) begin
          exp_oe = core_oe;
          check("R1 decode oe", pad_oe, exp_oe);
        end else if (m[2] == 1'b0 || m[0] == 1'b0) begin
          check("R2 decode oe", pad_oe, OBS);
        end else if (m[1]) begin
          check("R3 decode oe", pad_oe, '0);
        end else begin
          check("R4 decode oe", pad_oe, core_oe);
          check("R4 decode out", pad_out, core_out);
        end
      end
    end
  endtask

  task automatic t_full_stim();
    test_en_n = 1'b0; pad_in = STIM; settle();
    check("R6 final full", NP'(pad_out[25]), NP'(1));
    check("R6 tap full", NP'(pad_out[24]), NP'(1));
    pad_in[24] = 1'b1; pad_in[25] = 1'b1; settle();
    check("R5 obs in ignored final", NP'(pad_out[25]), NP'(1));
    check("R5 obs in ignored tap", NP'(pad_out[24]), NP'(1));
  endtask

  task automatic t_walk();
    test_en_n = 1'b0;
    for (int j = 0; j < LEN; j++) begin
      logic ef, et;
      pad_in = STIM;
      pad_in[pad_of(j)] = ~STIM[pad_of(j)];
      settle();
      ef = ((LEN - 1 - j) % 2) == 0;
      et = (j <= 11) ? (((11 - j) % 2) == 0) : 1'b1;
      check("R7 walk final", NP'(pad_out[25]), NP'(ef));
      check("R7 walk tap", NP'(pad_out[24]), NP'(et));
      check("R2 walk oe", pad_oe, OBS);
    end
  endtask

  task automatic t_hiz_obs();
    test_en_n = 1'b0; pad_in = STIM;
    pad_in[7] = 1'b1; pad_in[6] = 1'b1; pad_in[5] = 1'b1; settle();
    check("R3 obs off", pad_oe & OBS, '0);
    test_en_n = 1'b1; settle();
    check("R8 obs pass out", pad_out, core_out);
  endtask

  initial begin
    t_idle();
    t_decode();
    t_full_stim();
    t_walk();
    t_hiz_obs();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule